// File: doc/BRIEF.md
# Pipeline Interlock and Bypass Controller

This block is the data-hazard controller for a five-stage in-order integer pipeline whose stages are fetch, decode, execute, memory access and write-back. Each cycle it decodes the instruction word sitting in decode. It works out which source registers that instruction reads and which register, if any, it will write. It keeps a small tag (destination index, write enable, load flag, ALU flag) for each instruction in execute, memory and write-back. From the decode fields and those tags it produces a stall request and two operand-forwarding selects. The selects steer the operand multiplexers that sit in front of the ALU.

When stall is raised, the surrounding pipeline holds the PC and the decode instruction register. The controller replaces the instruction entering execute with a bubble that writes nothing. The parameter `BYP_MODE` picks the hazard policy. Mode 0 interlocks only. Mode 1 adds a single path that forwards the execute-stage ALU result into operand A. Mode 2 forwards fully from all three later stages, so only a load that is still in execute forces a wait.

The instruction word layout is opcode [31:26], rs [25:21], rt [20:16], rd [15:11]. The opcodes used are:

| Value | Instruction class |
|---|---|
| 0x00 | register-register ALU |
| 0x08 to 0x0F | ALU-immediate |
| 0x23 | load |
| 0x2B | store |
| 0x04 | branch-on-zero |
| 0x02 | jump |
| 0x03 | jump-and-link |
| 0x06 | jump-register |
| 0x07 | jump-and-link-register |

Any other opcode reads and writes nothing.

Top module: `hazard_ctrl`

## Requirements
- R1: The written register is rd [15:11] for opcode 0x00, rt [20:16] for opcodes 0x08 to 0x0F and load 0x23, and register 31 for jump-and-link 0x03 and jump-and-link-register 0x07.
- R2: Write enable is set for ALU, ALU-immediate and load only when the destination index is nonzero. It is always set for the two linking jumps and clear for all other opcodes, so a load or ALU-immediate aimed at register 0 causes no stall and no forwarding.
- R3: The rs field counts as read for ALU, ALU-immediate, load, store, branch-on-zero, jump-register and jump-and-link-register. The rt field counts as read only for register-register ALU and store. A field that is not read never causes a stall or a nonzero select.
- R4: With BYP_MODE=0, stall_o is 1 exactly when a read source of the decode instruction equals the destination of a write-enabled instruction in execute, memory or write-back. Both selects stay 0.
- R5: With BYP_MODE=1, fwd_a_o is 1 (execute) when rs is read and equals the destination of a write-enabled ALU or ALU-immediate in execute, and in that case no stall arises from it. Every other match stalls as in R4, and fwd_b_o stays 0.
- R6: With BYP_MODE=2, stall_o is 1 only when the execute instruction is a load with a nonzero destination that equals a read source of the decode instruction.
- R7: With BYP_MODE=2, each select encodes 0 = register file, 1 = execute, 2 = memory, 3 = write-back. It picks the youngest matching write-enabled stage (execute before memory before write-back) and never forwards register 0.
- R8: A cycle with stall_o high sends a write-disabled bubble into execute. Every cycle, the memory tag takes the old execute tag and the write-back tag takes the old memory tag.
- R9: Reset (rst_n low, asynchronous) clears all stage tags, so no stall or forwarding is produced until new instructions enter execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_instr | input | 32 | Instruction word currently in decode |
| stall_o | output | 1 | Hold PC and decode register, inject a bubble into execute |
| fwd_a_o | output | 2 | Operand A (rs) source select |
| fwd_b_o | output | 2 | Operand B (rt) source select |

## Verification
The hardest situation to reach from the ports is a load-use hazard. To create it, a load must sit in execute while its consumer waits in decode. The consumer must then be held for exactly one stalled cycle and must pick up the loaded value from the memory stage on the next cycle. The stimulus vector table drives this twice, once through rs and once through rt. It also places the same register in execute and memory at once to expose forwarding priority. Separate instances in the other two modes are walked through dependent sequences whose stall count (three cycles with no bypass) is predicted from stage depth alone.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int REG_W   = 5;
  localparam int LINK_REG = (1 << REG_W) - 1;

  localparam logic [OPC_W-1:0] OPC_ALU  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STOR = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BRZ  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JLNK = 6'h03;
  localparam logic [OPC_W-1:0] OPC_JREG = 6'h06;
  localparam logic [OPC_W-1:0] OPC_JRLK = 6'h07;
  localparam logic [2:0]       OPC_IMM_GRP = 3'b001;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } fwd_t;

  typedef struct packed {
    logic [REG_W-1:0] dest;
    logic             wr;
    logic             ld;
    logic             alu;
  } stage_t;

  function automatic logic src_hit(input logic [REG_W-1:0] src,
                                   input logic rd_en,
                                   input stage_t st);
    return rd_en && st.wr && (src != '0) && (st.dest == src);
  endfunction

  function automatic fwd_t fwd_pick(input logic [REG_W-1:0] src,
                                    input logic rd_en,
                                    input stage_t ex,
                                    input stage_t mem,
                                    input stage_t wb);
    fwd_t sel;
    if (src_hit(src, rd_en, ex))       sel = ex.ld ? SRC_RF : SRC_EX;
    else if (src_hit(src, rd_en, mem)) sel = SRC_MEM;
    else if (src_hit(src, rd_en, wb))  sel = SRC_WB;
    else                               sel = SRC_RF;
    return sel;
  endfunction

endpackage

// File: rtl/hazard_rst_sync.sv
module hazard_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/hazard_decode.sv
module hazard_decode
  import hazard_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic [REG_W-1:0]   rs,
  output logic [REG_W-1:0]   rt,
  output logic               rs_rd,
  output logic               rt_rd,
  output stage_t             tag
);
  logic [OPC_W-1:0] opc;
  logic [REG_W-1:0] rd;
  logic             unused_low;

  assign opc = instr[31:26];
  assign rs  = instr[25:21];
  assign rt  = instr[20:16];
  assign rd  = instr[15:11];
  assign unused_low = ^instr[10:0];

  always_comb begin
    tag   = '0;
    rs_rd = 1'b0;
    rt_rd = 1'b0;
    if (opc[5:3] == OPC_IMM_GRP) begin
      tag.dest = rt;
      tag.wr   = (rt != '0);
      tag.alu  = 1'b1;
      rs_rd    = 1'b1;
    end else begin
      case (opc)
        OPC_ALU: begin
          tag.dest = rd;
          tag.wr   = (rd != '0);
          tag.alu  = 1'b1;
          rs_rd    = 1'b1;
          rt_rd    = 1'b1;
        end
        OPC_LOAD: begin
          tag.dest = rt;
          tag.wr   = (rt != '0);
          tag.ld   = 1'b1;
          rs_rd    = 1'b1;
        end
        OPC_STOR: begin
          rs_rd = 1'b1;
          rt_rd = 1'b1;
        end
        OPC_BRZ, OPC_JREG: rs_rd = 1'b1;
        OPC_JLNK: begin
          tag.dest = REG_W'(LINK_REG);
          tag.wr   = 1'b1;
        end
        OPC_JRLK: begin
          tag.dest = REG_W'(LINK_REG);
          tag.wr   = 1'b1;
          rs_rd    = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hazard_track.sv
module hazard_track
  import hazard_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stall,
  input  stage_t dec_tag,
  output stage_t ex_q,
  output stage_t mem_q,
  output stage_t wb_q
);
  stage_t ex_d, mem_d, wb_d;

  always_comb begin
    ex_d  = stall ? stage_t'('0) : dec_tag;
    mem_d = ex_q;
    wb_d  = mem_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_q  <= '0;
      mem_q <= '0;
      wb_q  <= '0;
    end else begin
      ex_q  <= ex_d;
      mem_q <= mem_d;
      wb_q  <= wb_d;
    end
  end
endmodule

// File: rtl/hazard_resolve.sv
module hazard_resolve
  import hazard_pkg::*;
#(
  parameter int MODE = 2
) (
  input  logic [REG_W-1:0] rs,
  input  logic [REG_W-1:0] rt,
  input  logic             rs_rd,
  input  logic             rt_rd,
  input  stage_t           ex,
  input  stage_t           mem,
  input  stage_t           wb,
  output logic             stall,
  output fwd_t             sel_a,
  output fwd_t             sel_b
);
  logic a_ex, a_mem, a_wb, b_ex, b_mem, b_wb;
  logic unused_flags;

  assign a_ex  = src_hit(rs, rs_rd, ex);
  assign a_mem = src_hit(rs, rs_rd, mem);
  assign a_wb  = src_hit(rs, rs_rd, wb);
  assign b_ex  = src_hit(rt, rt_rd, ex);
  assign b_mem = src_hit(rt, rt_rd, mem);
  assign b_wb  = src_hit(rt, rt_rd, wb);
  assign unused_flags = ^{mem.ld, mem.alu, wb.ld, wb.alu};

  generate
    if (MODE == 0) begin : g_lock
      logic unused_ex;
      assign unused_ex = ^{ex.ld, ex.alu};
      assign stall = a_ex | a_mem | a_wb | b_ex | b_mem | b_wb;
      assign sel_a = SRC_RF;
      assign sel_b = SRC_RF;
    end else if (MODE == 1) begin : g_exa
      logic unused_ld;
      assign unused_ld = ex.ld;
      assign stall = (a_ex & ~ex.alu) | a_mem | a_wb | b_ex | b_mem | b_wb;
      assign sel_a = (a_ex & ex.alu) ? SRC_EX : SRC_RF;
      assign sel_b = SRC_RF;
    end else begin : g_full
      logic unused_alu;
      assign unused_alu = ex.alu;
      assign stall = ex.ld & (a_ex | b_ex);
      assign sel_a = fwd_pick(rs, rs_rd, ex, mem, wb);
      assign sel_b = fwd_pick(rt, rt_rd, ex, mem, wb);
    end
  endgenerate
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int BYP_MODE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] id_instr,
  output logic        stall_o,
  output logic [1:0]  fwd_a_o,
  output logic [1:0]  fwd_b_o
);
  logic             rst_sync_n;
  logic [REG_W-1:0] rs, rt;
  logic             rs_rd, rt_rd;
  stage_t           dec_tag, ex_q, mem_q, wb_q;
  fwd_t             sel_a, sel_b;
  logic             stall;

  hazard_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  hazard_decode u_dec (
    .instr(id_instr), .rs(rs), .rt(rt), .rs_rd(rs_rd), .rt_rd(rt_rd), .tag(dec_tag)
  );

  hazard_track u_trk (
    .clk(clk), .rst_n(rst_sync_n), .stall(stall), .dec_tag(dec_tag),
    .ex_q(ex_q), .mem_q(mem_q), .wb_q(wb_q)
  );

  hazard_resolve #(.MODE(BYP_MODE)) u_res (
    .rs(rs), .rt(rt), .rs_rd(rs_rd), .rt_rd(rt_rd),
    .ex(ex_q), .mem(mem_q), .wb(wb_q),
    .stall(stall), .sel_a(sel_a), .sel_b(sel_b)
  );

  assign stall_o = stall;
  assign fwd_a_o = sel_a;
  assign fwd_b_o = sel_b;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk
  import hazard_pkg::*;
#(
  parameter int MODE = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       stall,
  input logic [1:0] fwd_a,
  input logic [1:0] fwd_b,
  input stage_t     ex,
  input stage_t     mem,
  input stage_t     wb
);
  // R8: a stalled cycle leaves a write-disabled bubble in execute
  a_r8_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex.wr);

  // R8: tags advance one stage per cycle
  a_r8_shift: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mem == $past(ex)) && (wb == $past(mem)));

  // R6: full bypass stalls only behind a writing load in execute
  a_r6_load_only: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 2 && stall) |-> (ex.ld && ex.wr));

  // R4: interlock mode never forwards
  a_r4_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 0) |-> (fwd_a == 2'd0 && fwd_b == 2'd0));

  // R7: an execute select needs a writing non-load in execute
  a_r7_ex_src: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'd1 || fwd_b == 2'd1) |-> (ex.wr && !ex.ld));

  // R5: single-path mode never selects operand B or a later stage for A
  a_r5_a_only: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 1) |-> (fwd_b == 2'd0 && fwd_a != 2'd2 && fwd_a != 2'd3));

  // R9: tags are empty while reset is held
  always @(posedge clk) begin
    if (rst_n == 1'b0) begin
      a_r9_reset_clear: assert (ex == '0 && mem == '0 && wb == '0);
    end
  end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.MODE(BYP_MODE)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .stall(stall_o), .fwd_a(fwd_a_o), .fwd_b(fwd_b_o),
  .ex(ex_q), .mem(mem_q), .wb(wb_q)
);

// File: tb/tb_hazard_ctrl.sv
module tb_hazard_ctrl;

  localparam logic [5:0] T_ALU = 6'h00, T_IMM = 6'h08, T_LD = 6'h23, T_ST = 6'h2B;
  localparam logic [5:0] T_BZ = 6'h04, T_J = 6'h02, T_JL = 6'h03, T_JR = 6'h06, T_JRL = 6'h07;
  localparam logic [31:0] NOP = 32'h0;

  function automatic logic [31:0] rr(input logic [4:0] s, input logic [4:0] t, input logic [4:0] d);
    return {T_ALU, s, t, d, 11'h0};
  endfunction
  function automatic logic [31:0] ii(input logic [5:0] op, input logic [4:0] s, input logic [4:0] t);
    return {op, s, t, 16'h0};
  endfunction

  // {instr, stall, fwd_a, fwd_b} for the fully bypassed instance
  localparam int NV = 23;
  localparam logic [36:0] VEC [NV] = '{
    {rr(2,3,1),     1'b0, 2'd0, 2'd0},  // R1 empty pipe
    {rr(1,1,4),     1'b0, 2'd1, 2'd1},  // R7 both from execute
    {rr(1,4,5),     1'b0, 2'd2, 2'd1},  // R7 memory and execute
    {ii(T_ST,1,5),  1'b0, 2'd3, 2'd1},  // R3 store reads both
    {ii(T_LD,4,6),  1'b0, 2'd3, 2'd0},  // R3 load reads rs only
    {rr(6,0,7),     1'b1, 2'd0, 2'd0},  // R6 load-use stall
    {rr(6,0,7),     1'b0, 2'd2, 2'd0},  // R8 bubble, load now in memory
    {ii(T_JL,0,0),  1'b0, 2'd0, 2'd0},  // R3 link jump reads nothing
    {ii(T_JR,31,0), 1'b0, 2'd1, 2'd0},  // R1 link reg 31 from execute
    {ii(T_IMM,7,0), 1'b0, 2'd3, 2'd0},  // R2 immediate to r0
    {rr(0,31,8),    1'b0, 2'd0, 2'd3},  // R7 r0 never forwarded
    {ii(T_LD,8,0),  1'b0, 2'd1, 2'd0},  // R2 load to r0
    {rr(0,0,9),     1'b0, 2'd0, 2'd0},  // R2 no stall behind r0 load
    {rr(0,0,10),    1'b0, 2'd0, 2'd0},
    {rr(0,0,10),    1'b0, 2'd0, 2'd0},
    {rr(10,10,11),  1'b0, 2'd1, 2'd1},  // R7 execute beats memory
    {ii(T_J,10,10), 1'b0, 2'd0, 2'd0},  // R3 plain jump ignores fields
    {ii(T_BZ,11,11),1'b0, 2'd2, 2'd0},  // R3 branch rt not read
    {ii(T_LD,0,12), 1'b0, 2'd0, 2'd0},
    {ii(T_ST,0,12), 1'b1, 2'd0, 2'd0},  // R6 load-use through rt
    {ii(T_ST,0,12), 1'b0, 2'd0, 2'd2},  // R8 retry after bubble
    {ii(T_JRL,12,0),1'b0, 2'd3, 2'd0},  // R3 jalr reads rs
    {rr(31,0,13),   1'b0, 2'd1, 2'd0}   // R1 jalr writes r31
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] in_f, in_l, in_e;
  logic        st_f, st_l, st_e;
  logic [1:0]  fa_f, fb_f, fa_l, fb_l, fa_e, fb_e;
  int          errors = 0;
  int          checks = 0;

  always #5 clk = ~clk;

  hazard_ctrl #(.BYP_MODE(2)) dut (
    .clk(clk), .rst_n(rst_n), .id_instr(in_f), .stall_o(st_f), .fwd_a_o(fa_f), .fwd_b_o(fb_f));
  hazard_ctrl #(.BYP_MODE(0)) dut_lk (
    .clk(clk), .rst_n(rst_n), .id_instr(in_l), .stall_o(st_l), .fwd_a_o(fa_l), .fwd_b_o(fb_l));
  hazard_ctrl #(.BYP_MODE(1)) dut_ex (
    .clk(clk), .rst_n(rst_n), .id_instr(in_e), .stall_o(st_e), .fwd_a_o(fa_e), .fwd_b_o(fb_e));

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: stall/a/b actual=%b/%0d/%0d expected=%b/%0d/%0d",
               tag, act[4], act[3:2], act[1:0], exp[4], exp[3:2], exp[1:0]);
    end
  endtask

  task automatic step_f(input logic [31:0] i, input logic [4:0] exp, input string tag);
    @(negedge clk); in_f = i; #1;
    check(tag, {st_f, fa_f, fb_f}, exp);
  endtask
  task automatic step_l(input logic [31:0] i, input logic [4:0] exp, input string tag);
    @(negedge clk); in_l = i; #1;
    check(tag, {st_l, fa_l, fb_l}, exp);
  endtask
  task automatic step_e(input logic [31:0] i, input logic [4:0] exp, input string tag);
    @(negedge clk); in_e = i; #1;
    check(tag, {st_e, fa_e, fb_e}, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_f = NOP; in_l = NOP; in_e = NOP;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R9: empty tags after reset, dependent word gives nothing
    @(negedge clk); in_f = rr(1,1,2); in_l = rr(1,1,2); in_e = rr(1,1,2); #1;
    check("R9 reset full", {st_f, fa_f, fb_f}, 5'b0);
    check("R9 reset lock", {st_l, fa_l, fb_l}, 5'b0);
    check("R9 reset exa",  {st_e, fa_e, fb_e}, 5'b0);
    @(negedge clk); in_f = NOP; in_l = NOP; in_e = NOP;
    repeat (4) @(posedge clk);

    for (int k = 0; k < NV; k++)
      step_f(VEC[k][36:5], VEC[k][4:0], $sformatf("R6/R7 vec %0d", k));
    step_f(NOP, 5'b0, "R8 flush");

    // R4: interlock waits out execute, memory and write-back
    step_l(rr(2,3,1), 5'b0, "R4 producer");
    step_l(rr(1,0,4), 5'b10000, "R4 stall ex");
    step_l(rr(1,0,4), 5'b10000, "R4 stall mem");
    step_l(rr(1,0,4), 5'b10000, "R4 stall wb");
    step_l(rr(1,0,4), 5'b00000, "R4 released");
    step_l(ii(T_IMM,0,4), 5'b0, "R3 imm rt not read");
    step_l(ii(T_IMM,0,0), 5'b0, "R2 imm to r0");
    step_l(rr(0,0,5), 5'b0, "R2 no stall after r0 write");
    step_l(NOP, 5'b0, "R4 flush");

    // R5: single execute path for operand A
    step_e(rr(2,3,1), 5'b0, "R5 producer");
    step_e(rr(1,2,4), 5'b00100, "R5 A from execute");
    step_e(rr(0,4,5), 5'b10000, "R5 rt stall ex");
    step_e(rr(0,4,5), 5'b10000, "R5 rt stall mem");
    step_e(rr(0,4,5), 5'b10000, "R5 rt stall wb");
    step_e(rr(0,4,5), 5'b00000, "R5 released");
    step_e(ii(T_LD,0,6), 5'b0, "R5 load");
    step_e(rr(6,0,7), 5'b10000, "R5 load not forwarded");
    step_e(NOP, 5'b0, "R5 flush");

    // R9: reset in mid-run drops a pending load
    step_f(ii(T_LD,0,12), 5'b0, "R9 load before reset");
    @(posedge clk); #1;
    @(negedge clk); in_f = ii(T_LD,0,12);
    rst_n = 1'b0; #1;
    in_f = rr(12,12,13); #1;
    check("R9 mid-run reset", {st_f, fa_f, fb_f}, 5'b0);
    @(negedge clk); in_f = NOP; rst_n = 1'b1;
    repeat (4) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule